// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits between the serial shift engine of an SPI peripheral and the CPU bus. It owns two four-entry byte queues: a receive queue that the shift engine fills and the CPU drains, and a transmit queue that the CPU fills and the shift engine drains at the start of each transfer. It publishes a 16-bit status word with the fill level of each queue, sticky error and interrupt flags, and a level flag for surplus receive bytes. It also drives one interrupt line.

Interrupts come from a programmable byte count. A mode input picks which side is counted. With the mode low, accepted receive bytes are counted. With the mode high, transmitted bytes are counted. When the count reaches the threshold, the interrupt flag for that side sets and the count starts again. Errors are a push into a full receive queue and a transfer start with an empty transmit queue. Each error sets a sticky flag, and each may be kept off the interrupt line by that queue's flush enable. Reading the status word clears every sticky flag. An event that lands in the same cycle as the read is kept.

Top module: `spi_fifo_stat`

## Requirements
- R1: Reset empties both queues and clears the whole status word and `irq`. Status bits 15:12 always read 0.
- R2: Status bits 10:8 hold the receive fill level and bits 3:1 hold the transmit fill level, each in binary from 000 (empty) to 100 (full). Each queue returns bytes in the order they were pushed.
- R3: A receive push while the queue holds 4 bytes and no pop happens in the same cycle sets status bit 7. The incoming byte is dropped and the 4 stored bytes are kept.
- R4: A transfer start (`txPop`) with the transmit queue empty sets status bit 4 and presents 0x00 on `txDout` in that cycle.
- R5: With `rxFlushEn` high, status bit 7 still sets but does not contribute to bit 0 or `irq`. `txFlushEn` does the same for bit 4.
- R6: With `xferIrqMode` low, status bit 6 sets on the accepted receive byte that brings the byte counter to the threshold. The counter then restarts from zero. The counter also clears whenever the mode changes.
- R7: With `xferIrqMode` high, status bit 5 sets on the transmitted byte (a pop from a non-empty queue) that brings the counter to the threshold. Pushes into the transmit queue are not counted.
- R8: A threshold of 0 acts as 1, and a threshold above 4 acts as 4.
- R9: Status bit 11 is high exactly while the receive fill level is greater than the effective threshold. It is not sticky.
- R10: A status read (`statRead`) clears bits 7:4 on the next edge. A flag event in the same cycle as the read leaves that flag set.
- R11: Status bit 0 and `irq` equal the OR of bits 6 and 5, bit 7 when `rxFlushEn` is low, and bit 4 when `txFlushEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxPush | input | 1 | Shift engine delivers a received byte |
| rxData | input | 8 | Received byte |
| rxPop | input | 1 | CPU takes the head receive byte |
| rxDout | output | 8 | Head of the receive queue, 0 when empty |
| txPush | input | 1 | CPU writes a byte to send |
| txData | input | 8 | Byte to send |
| txPop | input | 1 | Shift engine starts a transfer and takes the head byte |
| txDout | output | 8 | Head of the transmit queue, 0x00 when empty |
| statRead | input | 1 | CPU reads the status word this cycle |
| xferIrqMode | input | 1 | 0: count received bytes, 1: count transmitted bytes |
| irqCount | input | 3 | Interrupt byte-count threshold |
| rxFlushEn | input | 1 | Keep receive overflow off the interrupt |
| txFlushEn | input | 1 | Keep transmit underflow off the interrupt |
| status | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the inputs are synchronous to `clk` and never unknown after reset. The clear-on-read property also assumes that only the two queue-side strobes, `rxPush` and `txPop`, can raise a sticky flag. The bench drives every input just after the falling edge and holds it for exactly one rising edge. It never asserts a push and a pop on the same queue in the same cycle, so the outcome of each stimulus is unambiguous. Before each scenario it resets the unit and programs the mode and threshold, so no byte count carries over from one task to the next.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 16;

  // accepted queue operations, issued by the control to the datapath
  typedef struct packed {
    logic rxWe;
    logic rxRe;
    logic txWe;
    logic txRe;
  } fifoStrobe_t;
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             we,
  input  logic [WIDTH-1:0] wData,
  input  logic             re,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we) begin
        mem[wrPtr] <= wData;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (re) rdPtr <= nextPtr(rdPtr);
      case ({we, re})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = (count != '0) ? mem[rdPtr] : '0;
endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strb,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxDout,
  output logic [DATA_W-1:0] txDout,
  output logic [CW-1:0]     rxCnt,
  output logic [CW-1:0]     txCnt
);
  logic [1:0]             weV, reV;
  logic [DATA_W-1:0]      wDataV [2];
  logic [DATA_W-1:0]      headV  [2];
  logic [CW-1:0]          cntV   [2];

  // lane 0: receive, lane 1: transmit
  assign weV       = {strb.txWe, strb.rxWe};
  assign reV       = {strb.txRe, strb.rxRe};
  assign wDataV[0] = rxData;
  assign wDataV[1] = txData;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    spi_fifo_buf #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_buf (
      .clk      (clk),
      .rstN     (rstN),
      .we       (weV[g]),
      .wData    (wDataV[g]),
      .re       (reV[g]),
      .headData (headV[g]),
      .count    (cntV[g])
    );
  end

  assign rxDout = headV[0];
  assign txDout = headV[1];
  assign rxCnt  = cntV[0];
  assign txCnt  = cntV[1];
endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPush,
  input  logic              rxPop,
  input  logic              txPush,
  input  logic              txPop,
  input  logic              statRead,
  input  logic              xferIrqMode,
  input  logic [2:0]        irqCount,
  input  logic              rxFlushEn,
  input  logic              txFlushEn,
  input  logic [CW-1:0]     rxCnt,
  input  logic [CW-1:0]     txCnt,
  output fifoStrobe_t       strb,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [CW-1:0] thrEff, xferCnt;
  logic          modeQ;
  logic          ovfEvt, unfEvt, cntEvt, hitEvt;
  logic          rxOvf, txUnf, rxIrq, txIrq, rxExcess, summary;

  // effective threshold: 0 -> 1, above DEPTH -> DEPTH
  always_comb begin
    if (irqCount == 3'd0)             thrEff = CW'(1);
    else if (int'(irqCount) > DEPTH)  thrEff = CW'(DEPTH);
    else                              thrEff = CW'(irqCount);
  end

  // accept / reject decisions
  always_comb begin
    strb.rxRe = rxPop && (rxCnt != '0);
    strb.rxWe = rxPush && ((rxCnt != CW'(DEPTH)) || strb.rxRe);
    strb.txRe = txPop && (txCnt != '0);
    strb.txWe = txPush && ((txCnt != CW'(DEPTH)) || strb.txRe);
    ovfEvt    = rxPush && !strb.rxWe;
    unfEvt    = txPop && (txCnt == '0);
    cntEvt    = xferIrqMode ? strb.txRe : strb.rxWe;
    hitEvt    = cntEvt && (({1'b0, xferCnt} + 1'b1) >= {1'b0, thrEff});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      xferCnt <= '0;
      rxOvf   <= 1'b0;
      txUnf   <= 1'b0;
      rxIrq   <= 1'b0;
      txIrq   <= 1'b0;
    end else begin
      modeQ <= xferIrqMode;
      if (modeQ != xferIrqMode) xferCnt <= '0;
      else if (cntEvt)          xferCnt <= hitEvt ? '0 : xferCnt + 1'b1;
      // read clears; a same-cycle event wins
      rxOvf <= (rxOvf & ~statRead) | ovfEvt;
      txUnf <= (txUnf & ~statRead) | unfEvt;
      rxIrq <= (rxIrq & ~statRead) | (hitEvt & ~xferIrqMode);
      txIrq <= (txIrq & ~statRead) | (hitEvt &  xferIrqMode);
    end
  end

  assign rxExcess = (rxCnt > thrEff);
  assign summary  = rxIrq | txIrq | (rxOvf & ~rxFlushEn) | (txUnf & ~txFlushEn);
  assign irq      = summary;
  assign status   = {4'b0000, rxExcess, 3'(rxCnt), rxOvf, rxIrq, txIrq, txUnf,
                     3'(txCnt), summary};
endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxPush,
  input  logic [7:0]  rxData,
  input  logic        rxPop,
  output logic [7:0]  rxDout,
  input  logic        txPush,
  input  logic [7:0]  txData,
  input  logic        txPop,
  output logic [7:0]  txDout,
  input  logic        statRead,
  input  logic        xferIrqMode,
  input  logic [2:0]  irqCount,
  input  logic        rxFlushEn,
  input  logic        txFlushEn,
  output logic [15:0] status,
  output logic        irq
);
  fifoStrobe_t   strb;
  logic [CW-1:0] rxCnt, txCnt;

  spi_fifo_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxPop(rxPop),
    .txPush(txPush), .txPop(txPop), .statRead(statRead),
    .xferIrqMode(xferIrqMode), .irqCount(irqCount),
    .rxFlushEn(rxFlushEn), .txFlushEn(txFlushEn),
    .rxCnt(rxCnt), .txCnt(txCnt), .strb(strb), .status(status), .irq(irq)
  );

  spi_fifo_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxData(rxData), .txData(txData),
    .rxDout(rxDout), .txDout(txDout), .rxCnt(rxCnt), .txCnt(txCnt)
  );
endmodule

// File: rtl/spi_fifo_stat_chk.sv
module spi_fifo_stat_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rxPush,
  input logic        rxPop,
  input logic        txPop,
  input logic [7:0]  txDout,
  input logic        statRead,
  input logic        xferIrqMode,
  input logic        rxFlushEn,
  input logic [15:0] status,
  input logic        irq
);
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (status[10:8] <= 3'd4) && (status[3:1] <= 3'd4));

  p_ovf_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && !rxPop && status[10:8] == 3'd4) |=> (status[7] && status[10:8] == 3'd4));

  p_unf_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && status[3:1] == 3'd0) |=> status[4]);

  p_unf_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && status[3:1] == 3'd0) |-> (txDout == 8'h00));

  p_ovf_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    (status[7] && !rxFlushEn) |-> irq);

  p_rx_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[6]) |-> $past(!xferIrqMode));

  p_read_clr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statRead && !rxPush && !txPop) |=> (status[7:4] == 4'b0000));
endmodule

bind spi_fifo_stat spi_fifo_stat_chk u_chk (
  .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxPop(rxPop), .txPop(txPop),
  .txDout(txDout), .statRead(statRead), .xferIrqMode(xferIrqMode),
  .rxFlushEn(rxFlushEn), .status(status), .irq(irq)
);

// File: tb/sim_spi_fifo_stat.sv
module sim_spi_fifo_stat;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxPush = 0, rxPop = 0, txPush = 0, txPop = 0, statRead = 0;
  logic [7:0]  rxData = 0, txData = 0;
  logic        xferIrqMode = 0, rxFlushEn = 0, txFlushEn = 0;
  logic [2:0]  irqCount = 3'd4;
  logic [7:0]  rxDout, txDout;
  logic [15:0] status;
  logic        irq;
  int          nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  spi_fifo_stat u0 (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxData(rxData), .rxPop(rxPop),
    .rxDout(rxDout), .txPush(txPush), .txData(txData), .txPop(txPop),
    .txDout(txDout), .statRead(statRead), .xferIrqMode(xferIrqMode),
    .irqCount(irqCount), .rxFlushEn(rxFlushEn), .txFlushEn(txFlushEn),
    .status(status), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic mode, input logic [2:0] thr);
    @(negedge clk);
    rstN = 1'b0; xferIrqMode = mode; irqCount = thr; rxFlushEn = 0; txFlushEn = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pushRx(input logic [7:0] d);
    rxPush = 1; rxData = d; @(negedge clk); rxPush = 0;
  endtask
  task automatic popRx(output logic [7:0] d);
    rxPop = 1; #1 d = rxDout; @(negedge clk); rxPop = 0;
  endtask
  task automatic pushTx(input logic [7:0] d);
    txPush = 1; txData = d; @(negedge clk); txPush = 0;
  endtask
  task automatic popTx(output logic [7:0] d);
    txPop = 1; #1 d = txDout; @(negedge clk); txPop = 0;
  endtask
  task automatic readStat();
    statRead = 1; @(negedge clk); statRead = 0;
  endtask

  task automatic tResetState();
    doReset(0, 3'd4);
    check("R1 status after reset", status, 16'h0000);
    check("R1 irq after reset", irq, 0);
    check("R1 rxDout empty", rxDout, 8'h00);
  endtask

  task automatic tRxThreshold();
    doReset(0, 3'd4);
    for (int i = 0; i < 3; i++) pushRx(8'h10 + 8'(i));
    check("R6 rx irq below threshold", status[6], 0);
    check("R2 rx level 3", status[10:8], 3'b011);
    pushRx(8'h13);
    check("R6 rx irq at threshold", status[6], 1);
    check("R2 rx level full", status[10:8], 3'b100);
    check("R11 summary bit", status[0], 1);
    check("R11 irq line", irq, 1);
    check("R1 reserved bits", status[15:12], 4'h0);
  endtask

  task automatic tOverflow();
    logic [7:0] d;
    doReset(0, 3'd4);
    for (int i = 0; i < 4; i++) pushRx(8'hA0 + 8'(i));
    readStat();
    check("R10 read cleared rx irq", status[6], 0);
    pushRx(8'hEE);
    check("R3 overflow flag", status[7], 1);
    check("R3 level held at 4", status[10:8], 3'b100);
    check("R11 irq from overflow", irq, 1);
    for (int i = 0; i < 4; i++) begin
      popRx(d);
      check("R3 R2 stored byte order", d, 8'hA0 + 8'(i));
    end
    check("R2 rx empty after drain", status[10:8], 3'b000);
    readStat();
    check("R10 sticky bits cleared", status[7:4], 4'b0000);
    check("R11 irq low after read", irq, 0);
  endtask

  task automatic tRxFlushGate();
    doReset(0, 3'd4);
    rxFlushEn = 1;
    for (int i = 0; i < 4; i++) pushRx(8'h55);
    readStat();
    pushRx(8'h66);
    check("R5 overflow flag still sets", status[7], 1);
    check("R5 summary gated", status[0], 0);
    check("R5 irq gated", irq, 0);
  endtask

  task automatic tUnderflow();
    logic [7:0] d;
    doReset(0, 3'd4);
    popTx(d);
    check("R4 underflow sends zero", d, 8'h00);
    check("R4 underflow flag", status[4], 1);
    check("R11 irq from underflow", irq, 1);
    readStat();
    check("R10 underflow cleared", status[4], 0);
    txFlushEn = 1;
    popTx(d);
    check("R5 underflow flag with flush", status[4], 1);
    check("R5 underflow irq gated", irq, 0);
  endtask

  task automatic tTxIrq();
    logic [7:0] d;
    doReset(1, 3'd2);
    pushTx(8'h11); pushTx(8'h22); pushTx(8'h33);
    check("R2 tx level 3", status[3:1], 3'b011);
    check("R7 pushes not counted", status[5], 0);
    popTx(d);
    check("R2 tx first byte", d, 8'h11);
    check("R7 tx irq below threshold", status[5], 0);
    popTx(d);
    check("R2 tx second byte", d, 8'h22);
    check("R7 tx irq at threshold", status[5], 1);
    check("R6 rx irq idle in tx mode", status[6], 0);
    check("R2 tx level 1", status[3:1], 3'b001);
  endtask

  task automatic tExcess();
    logic [7:0] d;
    doReset(0, 3'd2);
    pushRx(8'h01); pushRx(8'h02);
    check("R9 excess low at threshold", status[11], 0);
    pushRx(8'h03);
    check("R9 excess high above threshold", status[11], 1);
    popRx(d);
    check("R9 excess drops", status[11], 0);
  endtask

  task automatic tThresholdClamp();
    doReset(0, 3'd0);
    pushRx(8'h01);
    check("R8 zero threshold acts as one", status[6], 1);
    doReset(0, 3'd5);
    for (int i = 0; i < 3; i++) pushRx(8'h02);
    check("R8 large threshold not reached", status[6], 0);
    pushRx(8'h02);
    check("R8 large threshold clamps to 4", status[6], 1);
    check("R9 no excess at clamp", status[11], 0);
  endtask

  task automatic tReadRace();
    doReset(0, 3'd1);
    pushRx(8'h01);
    check("R6 rx irq threshold one", status[6], 1);
    rxPush = 1; rxData = 8'h02; statRead = 1;
    @(negedge clk);
    rxPush = 0; statRead = 0;
    check("R10 same-cycle event kept", status[6], 1);
    readStat();
    check("R10 plain read clears", status[6], 0);
    check("R2 level unaffected by read", status[10:8], 3'b010);
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    tResetState();
    tRxThreshold();
    tOverflow();
    tRxFlushGate();
    tUnderflow();
    tTxIrq();
    tExcess();
    tThresholdClamp();
    tReadRace();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule